// File: doc/BRIEF.md
# Flash Power Mode Controller

This block manages the power state of a parallel NOR-style flash device model. It samples the active-low chip-select, output-enable, write-enable and power-down pins, the address bus, and a busy flag from the program/erase engine on every clock edge. From these it selects one of four power modes and reports it as a two-bit code. It also drives the enable for the data output drivers and sends an abort strobe to the program/erase engine. A clear strobe goes to the status register. Two flags tell the rest of the device when reads and writes are allowed again after a power-down.

Power-down (`pd_n` low) wins over everything. A program or erase in progress keeps the device active even after chip-select is released. After a read, if the address stays the same for a set number of cycles, the device drops into an automatic saving mode. The data outputs keep driving the last word in that mode. When power-down is released, two down-counters set separate recovery times for reads and for writes. All pins are plain control signals with no handshake, because nothing streams through this block. The array, command decoder and program/erase algorithms are outside the block; they reach it only through `pe_busy`, `pe_abort` and `sts_clear`.

Top module: `flash_pwr_ctrl`

## Requirements
- R1: Mode codes are 0 = active, 1 = auto-save, 2 = standby, 3 = deep power-down. With `pd_n` high and `cs_n` low, `mode` becomes 0 one cycle after an edge where the address changed, or where the auto-save conditions are not met.
- R2: A read cycle is a cycle in mode 0 or 1 where `cs_n` is low, `pd_n` is high, `oe_n` is low, `we_n` is high and `rd_ready` is 1. After a read cycle, a counter counts edges where the address stays the same as the previous edge and the chip stays selected and powered. When the counter has reached IDLE_CYC, the next such edge sets `mode` to 1. Mode 1 then holds until the address changes, and `dq_oe` keeps following the read-cycle rule.
- R3: A change of address at an edge while in mode 1 (with `cs_n` low and `pd_n` high) returns `mode` to 0 one cycle later, and restarts the idle count.
- R4: With `pd_n` high, `cs_n` high and `pe_busy` low at an edge, `mode` becomes 2 one cycle later. `dq_oe` is 0 whenever `cs_n` is high, whatever `oe_n` is.
- R5: With `pd_n` high, `cs_n` high and `pe_busy` high at an edge, `mode` becomes 0 one cycle later, so the operation keeps running. Standby follows only once `pe_busy` falls.
- R6: With `pd_n` low at an edge, `mode` becomes 3 one cycle later, whatever the other pins are. `dq_oe` is 0 while `pd_n` is low.
- R7: An edge where `pd_n` is low, `mode` is not 3 and `pe_busy` is high drives `pe_abort` high for exactly the next cycle.
- R8: `data_invalid` goes to 1 together with `pe_abort`. It stays 1 until an edge where `pe_busy` is high after being low at the previous edge, and then returns to 0 one cycle later.
- R9: `sts_clear` is a one-cycle pulse. It is raised on the first edge after the power-on reset (`por_n`) is released, and on every edge where `pd_n` is low while `mode` is not 3.
- R10: `rd_ready` is 0 during reset and while `pd_n` is low. It becomes 1 after RD_REC consecutive edges with `pd_n` high.
- R11: `wr_ready` follows the same rule as `rd_ready`, with its own count of WR_REC edges.
- R12: `dq_oe` is 1 exactly in a read cycle as defined in R2. It is a combinational result of the pins and the registered state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| pd_n | input | 1 | Reset / power-down pin, active low |
| addr | input | AW | Address bus |
| pe_busy | input | 1 | Program/erase engine busy |
| mode | output | 2 | Power mode code (R1) |
| dq_oe | output | 1 | Data output driver enable |
| pe_abort | output | 1 | One-cycle abort to program/erase engine |
| sts_clear | output | 1 | One-cycle status register clear |
| data_invalid | output | 1 | Aborted target holds invalid data |
| rd_ready | output | 1 | Read recovery complete |
| wr_ready | output | 1 | Write recovery complete |

## Verification
The bench aims at edges where several pins change together. Examples are power-down falling while chip-select rises with the engine busy, and an address change in the same cycle as a read. A design with the wrong priority would go to standby instead of deep power-down, or leave the abort out. Long stable-address runs test the idle counter boundary; an off-by-one design would enter auto-save a cycle early or late. Recovery windows are cut short by repeated power-down pulses; a counter that does not reload would raise `rd_ready` or `wr_ready` too soon. Deselecting while busy checks that a design which drops to standby right away is caught.

// File: rtl/fpc_pkg.sv
package fpc_pkg;
  typedef enum logic [1:0] {
    PM_ACTIVE   = 2'd0,
    PM_AUTOSAVE = 2'd1,
    PM_STANDBY  = 2'd2,
    PM_DEEP     = 2'd3
  } pmode_e;
endpackage

// File: rtl/fpc_recov_timer.sv
// Down-counter that reloads while power-down is held and reports ready at zero.
module fpc_recov_timer #(
  parameter int CYCLES = 6
) (
  input  logic clk,
  input  logic por_n,
  input  logic pd_n,
  output logic ready
);
  localparam int CW = $clog2(CYCLES + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)              cnt_q <= LOAD;
    else if (!pd_n)          cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign ready = (cnt_q == '0);
endmodule

// File: rtl/fpc_idle_detect.sv
// Address change detection and post-read idle counting.
module fpc_idle_detect #(
  parameter int AW       = 8,
  parameter int IDLE_CYC = 4
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          pd_n,
  input  logic          cs_n,
  input  logic [AW-1:0] addr,
  input  logic          read_now,
  output logic          addr_chg,
  output logic          idle_hit
);
  localparam int IW = $clog2(IDLE_CYC + 1);
  localparam logic [IW-1:0] ILIM = IW'(IDLE_CYC);

  logic [AW-1:0] addr_q;
  logic          rd_seen_q;
  logic [IW-1:0] idle_q;
  logic          off;

  assign addr_chg = (addr != addr_q);
  assign off      = !pd_n || cs_n;
  assign idle_hit = (idle_q == ILIM);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      addr_q    <= '0;
      rd_seen_q <= 1'b0;
      idle_q    <= '0;
    end else begin
      addr_q <= addr;
      if (off)           rd_seen_q <= 1'b0;
      else if (read_now) rd_seen_q <= 1'b1;
      else if (addr_chg) rd_seen_q <= 1'b0;
      if (off || addr_chg || !rd_seen_q) idle_q <= '0;
      else if (idle_q != ILIM)           idle_q <= idle_q + 1'b1;
    end
  end
endmodule

// File: rtl/fpc_mode_fsm.sv
// Mode selection with pin priority, abort, status clear and invalid-data flag.
module fpc_mode_fsm
  import fpc_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  input  logic   pd_n,
  input  logic   cs_n,
  input  logic   pe_busy,
  input  logic   addr_chg,
  input  logic   idle_hit,
  output pmode_e mode,
  output logic   pe_abort,
  output logic   sts_clear,
  output logic   data_invalid
);
  pmode_e mode_q, mode_d;
  logic   por_done_q, busy_q, abort_q, clr_q, inval_q;
  logic   enter_deep, abort_d;

  assign enter_deep = !pd_n && (mode_q != PM_DEEP);
  assign abort_d    = enter_deep && pe_busy;

  always_comb begin
    if (!pd_n)                                mode_d = PM_DEEP;
    else if (cs_n)                            mode_d = pe_busy ? PM_ACTIVE : PM_STANDBY;
    else if (addr_chg)                        mode_d = PM_ACTIVE;
    else if (mode_q == PM_AUTOSAVE || idle_hit) mode_d = PM_AUTOSAVE;
    else                                      mode_d = PM_ACTIVE;
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      mode_q     <= PM_DEEP;
      por_done_q <= 1'b0;
      busy_q     <= 1'b0;
      abort_q    <= 1'b0;
      clr_q      <= 1'b0;
      inval_q    <= 1'b0;
    end else begin
      mode_q     <= mode_d;
      por_done_q <= 1'b1;
      busy_q     <= pe_busy;
      abort_q    <= abort_d;
      clr_q      <= !por_done_q || enter_deep;
      if (abort_d)                inval_q <= 1'b1;
      else if (pe_busy && !busy_q) inval_q <= 1'b0;
    end
  end

  assign mode         = mode_q;
  assign pe_abort     = abort_q;
  assign sts_clear    = clr_q;
  assign data_invalid = inval_q;
endmodule

// File: rtl/flash_pwr_ctrl.sv
module flash_pwr_ctrl
  import fpc_pkg::*;
#(
  parameter int AW       = 8,
  parameter int IDLE_CYC = 4,
  parameter int RD_REC   = 6,
  parameter int WR_REC   = 10
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic          pd_n,
  input  logic [AW-1:0] addr,
  input  logic          pe_busy,
  output logic [1:0]    mode,
  output logic          dq_oe,
  output logic          pe_abort,
  output logic          sts_clear,
  output logic          data_invalid,
  output logic          rd_ready,
  output logic          wr_ready
);
  pmode_e cur_mode;
  logic   addr_chg, idle_hit, read_now;

  assign read_now = (cur_mode == PM_ACTIVE || cur_mode == PM_AUTOSAVE) &&
                    !cs_n && pd_n && !oe_n && we_n && rd_ready;

  fpc_recov_timer #(.CYCLES(RD_REC)) u_rd_rec (
    .clk(clk), .por_n(por_n), .pd_n(pd_n), .ready(rd_ready));

  fpc_recov_timer #(.CYCLES(WR_REC)) u_wr_rec (
    .clk(clk), .por_n(por_n), .pd_n(pd_n), .ready(wr_ready));

  fpc_idle_detect #(.AW(AW), .IDLE_CYC(IDLE_CYC)) u_idle (
    .clk(clk), .por_n(por_n), .pd_n(pd_n), .cs_n(cs_n), .addr(addr),
    .read_now(read_now), .addr_chg(addr_chg), .idle_hit(idle_hit));

  fpc_mode_fsm u_fsm (
    .clk(clk), .por_n(por_n), .pd_n(pd_n), .cs_n(cs_n), .pe_busy(pe_busy),
    .addr_chg(addr_chg), .idle_hit(idle_hit), .mode(cur_mode),
    .pe_abort(pe_abort), .sts_clear(sts_clear), .data_invalid(data_invalid));

  assign mode  = cur_mode;
  assign dq_oe = read_now;
endmodule

// File: rtl/flash_pwr_ctrl_chk.sv
module flash_pwr_ctrl_chk (
  input logic       clk,
  input logic       por_n,
  input logic       cs_n,
  input logic       pd_n,
  input logic       pe_busy,
  input logic [1:0] mode,
  input logic       dq_oe,
  input logic       pe_abort,
  input logic       sts_clear,
  input logic       rd_ready
);
  a_r6_deep_entry: assert property (@(posedge clk) disable iff (!por_n)
    !pd_n |=> mode == 2'd3);

  a_r4_standby_hiz: assert property (@(posedge clk) disable iff (!por_n)
    cs_n |-> !dq_oe);

  a_r5_busy_holds: assert property (@(posedge clk) disable iff (!por_n)
    (pd_n && cs_n && pe_busy) |=> mode == 2'd0);

  a_r7_abort_single: assert property (@(posedge clk) disable iff (!por_n)
    pe_abort |=> !pe_abort);

  a_r7_abort_cause: assert property (@(posedge clk) disable iff (!por_n)
    pe_abort |-> (mode == 2'd3 && $past(pe_busy)));

  a_r9_clear_on_entry: assert property (@(posedge clk) disable iff (!por_n)
    (mode == 2'd3 && $past(mode) != 2'd3) |-> sts_clear);

  a_r10_read_blocked: assert property (@(posedge clk) disable iff (!por_n)
    !rd_ready |-> !dq_oe);
endmodule

bind flash_pwr_ctrl flash_pwr_ctrl_chk u_chk (
  .clk(clk), .por_n(por_n), .cs_n(cs_n), .pd_n(pd_n), .pe_busy(pe_busy),
  .mode(mode), .dq_oe(dq_oe), .pe_abort(pe_abort), .sts_clear(sts_clear),
  .rd_ready(rd_ready));

// File: tb/test_flash_pwr_ctrl.sv
module test_flash_pwr_ctrl;
  localparam int AW = 8, IDLE = 4, RDR = 6, WRR = 10;

  logic clk = 1'b0, por_n = 1'b0;
  logic cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, pd_n = 1'b1, pe_busy = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [1:0] mode;
  logic dq_oe, pe_abort, sts_clear, data_invalid, rd_ready, wr_ready;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 1'b0;

  // reference state
  int m_mode, m_prev, m_idle, m_rcnt, m_wcnt;
  bit m_rd_seen, m_busy_q, m_por_done, m_abort, m_clr, m_inval;
  logic [AW-1:0] m_addr_q;

  always #2.5 clk = ~clk;

  flash_pwr_ctrl #(.AW(AW), .IDLE_CYC(IDLE), .RD_REC(RDR), .WR_REC(WRR)) i_flash_pwr_ctrl (
    .clk(clk), .por_n(por_n), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n), .pd_n(pd_n),
    .addr(addr), .pe_busy(pe_busy), .mode(mode), .dq_oe(dq_oe), .pe_abort(pe_abort),
    .sts_clear(sts_clear), .data_invalid(data_invalid), .rd_ready(rd_ready),
    .wr_ready(wr_ready));

  function automatic bit exp_read();
    return (m_mode == 0 || m_mode == 1) && !cs_n && pd_n && !oe_n && we_n && (m_rcnt == 0);
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s cycle %0d actual %0d expected %0d", tag, cyc, act, exp);
    end
  endtask

  task automatic model_reset();
    m_mode = 3; m_prev = 3; m_idle = 0; m_rcnt = RDR; m_wcnt = WRR;
    m_rd_seen = 0; m_busy_q = 0; m_por_done = 0; m_abort = 0; m_clr = 0; m_inval = 0;
    m_addr_q = '0;
  endtask

  // advance the reference across one clock edge using the pins now applied
  task automatic model_step();
    bit chg, rd, off, ab;
    int nm;
    chg = (addr != m_addr_q);
    rd  = exp_read();
    off = !pd_n || cs_n;
    ab  = !pd_n && m_mode != 3 && pe_busy;
    if (!pd_n)                          nm = 3;
    else if (cs_n)                      nm = pe_busy ? 0 : 2;
    else if (chg)                       nm = 0;
    else if (m_mode == 1 || m_idle == IDLE) nm = 1;
    else                                nm = 0;
    if (off || chg || !m_rd_seen) m_idle = 0;
    else if (m_idle != IDLE)      m_idle++;
    if (off)      m_rd_seen = 0;
    else if (rd)  m_rd_seen = 1;
    else if (chg) m_rd_seen = 0;
    m_clr = !m_por_done || (!pd_n && m_mode != 3);
    m_por_done = 1;
    if (ab)                        m_inval = 1;
    else if (pe_busy && !m_busy_q) m_inval = 0;
    m_abort  = ab;
    m_busy_q = pe_busy;
    m_addr_q = addr;
    m_rcnt = !pd_n ? RDR : (m_rcnt != 0 ? m_rcnt - 1 : 0);
    m_wcnt = !pd_n ? WRR : (m_wcnt != 0 ? m_wcnt - 1 : 0);
    m_prev = m_mode;
    m_mode = nm;
  endtask

  task automatic check_all();
    string mt;
    if (m_mode == 3)                       mt = "R6";
    else if (m_mode == 2)                  mt = "R4";
    else if (m_mode == 1)                  mt = "R2";
    else if (m_prev == 1)                  mt = "R3";
    else if (m_prev != 3 && cs_n == 1'b1)  mt = "R5";
    else                                   mt = "R1";
    chk(mt, mode, m_mode);
    chk(cs_n ? "R4 dq_oe" : (!pd_n ? "R6 dq_oe" : "R12 dq_oe"), dq_oe, exp_read());
    chk("R10 rd_ready", rd_ready, m_rcnt == 0);
    chk("R11 wr_ready", wr_ready, m_wcnt == 0);
    chk("R7 pe_abort", pe_abort, m_abort);
    chk("R9 sts_clear", sts_clear, m_clr);
    chk("R8 data_invalid", data_invalid, m_inval);
  endtask

  // one cycle: check at falling edge, then apply next pins and advance model
  task automatic cycle(bit c, bit o, bit w, bit p, bit b, logic [AW-1:0] a);
    @(negedge clk);
    cyc++;
    check_all();
    cs_n = c; oe_n = o; we_n = w; pd_n = p; pe_busy = b; addr = a;
    model_step();
  endtask

  initial begin
    int phase;
    bit b;
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // reset state: deep mode, not ready, no strobes
    chk("R6 reset mode", mode, 3);
    chk("R10 reset rd_ready", rd_ready, 0);
    chk("R11 reset wr_ready", wr_ready, 0);
    chk("R9 reset sts_clear", sts_clear, 0);
    por_n = 1'b1;
    cs_n = 1'b0; oe_n = 1'b0;
    model_step();
    // directed: recovery, reads at one address into auto-save, then address change (R2, R3, R10)
    repeat (RDR + IDLE + 8) cycle(0, 0, 1, 1, 0, 8'h12);
    cycle(0, 0, 1, 1, 0, 8'h13);
    repeat (3) cycle(0, 0, 1, 1, 0, 8'h13);
    // directed: deselect while busy, then busy drops (R5, R4)
    repeat (4) cycle(1, 0, 1, 1, 1, 8'h13);
    repeat (3) cycle(1, 0, 1, 1, 0, 8'h13);
    // directed: power-down while busy and deselecting together (R6, R7, R8, R9)
    cycle(1, 0, 1, 1, 1, 8'h20);
    cycle(1, 0, 1, 0, 1, 8'h21);
    repeat (3) cycle(0, 0, 1, 0, 0, 8'h21);
    repeat (WRR + 3) cycle(0, 0, 1, 1, 0, 8'h21);
    cycle(0, 1, 0, 1, 1, 8'h21); // busy restarts: invalid clears (R8)
    repeat (3) cycle(0, 1, 1, 1, 0, 8'h21);
    // constrained random
    b = 0; a = 8'h40; phase = 0;
    for (int i = 0; i < 4000; i++) begin
      if (i % 64 == 0) phase = $urandom_range(0, 2);
      if ($urandom_range(0, 9) == 0) b = ~b;
      if ($urandom_range(0, phase == 0 ? 15 : 4) == 0) a = AW'($urandom);
      cycle($urandom_range(0, 99) < (phase == 1 ? 40 : 8),
            $urandom_range(0, 99) < 25,
            $urandom_range(0, 99) < 10,
            !($urandom_range(0, 99) < (phase == 2 ? 15 : 1)),
            b, a);
    end
    @(negedge clk);
    check_all();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired at cycle %0d actual 0 expected 1", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule